// File: doc/BRIEF.md
# Prefix Route Lookup Engine

This block resolves a destination address to an output port. A ternary pattern table holds destination prefixes, where each bit is either a required 0, a required 1 or a don't-care bit. A port table beside it holds one output-port number per row. Each incoming key is compared against every live pattern in parallel. The lowest-numbered matching row becomes the read pointer into the port table. The block returns a hit flag and the port held in that row.

A management write sets one row. In a single cycle it writes the pattern value, the care mask, a live flag and the port number, all at the same row index. Entries are not sorted by the hardware. Software places longer prefixes at lower row numbers, so the lowest-index winner is always the longest matching prefix.

Lookups are pipelined and accept one key per clock. The first stage registers the search result and the second stage registers the port read. A key that matches no live row returns the hit flag low and a port value fixed by a parameter (the default route).

Top module: `route_lookup_engine`

## Requirements
- R1: While rst_n is low and after it rises, res_valid and res_hit are low. Every row is not live after reset, so a lookup made before any write misses.
- R2: A lookup with lk_req high at a rising edge produces res_valid high after exactly the second rising edge that follows. Back-to-back requests give one result per clock in request order. res_valid is low in every other cycle.
- R3: Row i matches key k when it is live and, for every bit b with care bit 1, k[b] equals value bit b. Bits with care bit 0 match both 0 and 1. For example, value 10100 with care 11100 covers keys 10100 through 10111.
- R4: When several live rows match, the row with the lowest index wins. With the table 101XX, 0110X, 011XX, 10011 at rows 0 to 3, key 01101 selects row 1.
- R5: On a hit, res_port equals the port number stored at the winning row.
- R6: When no live row matches, res_hit is low and res_port equals DEFAULT_PORT.
- R7: A write with wr_en high updates the value, care mask, live flag and port of row wr_idx at one edge. Lookups sampled at later edges see the new entry. A write with wr_live low removes the row from matching.
- R8: A lookup sampled at the same edge as a write uses the patterns from before that write, but reads the port table after it. So a port written to the winning row at that edge is the port returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | IDX_W | Row written |
| wr_value | input | KEY_W | Pattern bits for the row |
| wr_care | input | KEY_W | Care mask, 1 = bit must match |
| wr_live | input | 1 | Row takes part in searches when 1 |
| wr_port | input | PORT_W | Output port stored for the row |
| lk_req | input | 1 | Lookup request strobe |
| lk_key | input | KEY_W | Destination address to search |
| res_valid | output | 1 | Result strobe, two clocks after the request |
| res_hit | output | 1 | A live row matched |
| res_port | output | PORT_W | Port of the winning row, or DEFAULT_PORT on a miss |

## Verification
Every result is due at the second rising edge after its request edge. A table write changes patterns for lookups sampled at the next edge, and it changes ports for reads one edge later. The bench's behavioural model advances at each rising edge in that same order: it produces the output stage first, then the search stage, then applies the write. The bench compares res_valid, res_hit and res_port against the model at every falling edge, so each output is sampled half a clock after the edge that set it. The stimulus includes ranges, overlapping prefixes, misses, deletions and writes that collide with lookups in flight.

// File: rtl/lkup_pkg.sv
package lkup_pkg;
   function automatic int unsigned idx_width(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/tcam_bank.sv
module tcam_bank #(
   parameter int unsigned KEY_W   = 5,
   parameter int unsigned ENTRIES = 8,
   parameter int unsigned IDX_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [KEY_W-1:0]   wr_value,
   input  logic [KEY_W-1:0]   wr_care,
   input  logic               wr_live,
   input  logic [KEY_W-1:0]   key,
   output logic [ENTRIES-1:0] match_vec
);
   initial begin
      assert (KEY_W > 0) else $error("tcam_bank: KEY_W must be positive");
      assert (ENTRIES >= 2 && ENTRIES <= (1 << IDX_W))
         else $error("tcam_bank: ENTRIES out of range for IDX_W");
   end

   for (genvar g = 0; g < ENTRIES; g++) begin : g_row
      logic [KEY_W-1:0] pat_q;
      logic [KEY_W-1:0] care_q;
      logic             live_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pat_q  <= '0;
            care_q <= '0;
            live_q <= 1'b0;
         end else if (wr_en && (wr_idx == IDX_W'(g))) begin
            pat_q  <= wr_value;
            care_q <= wr_care;
            live_q <= wr_live;
         end
      end

      // a cell mismatches only where a cared bit differs
      assign match_vec[g] = live_q && (((key ^ pat_q) & care_q) == '0);
   end

   // R7: a row just written live matches its own pattern at the next search
   p_write_visible_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_en) && $past(wr_live) && (key == $past(wr_value)))
         |-> match_vec[$past(wr_idx)]);
endmodule

// File: rtl/first_set_encoder.sv
module first_set_encoder #(
   parameter int unsigned ENTRIES = 8,
   parameter int unsigned IDX_W   = 3
) (
   input  logic [ENTRIES-1:0] vec,
   output logic               any,
   output logic [IDX_W-1:0]   idx
);
   initial begin
      assert (ENTRIES <= (1 << IDX_W)) else $error("first_set_encoder: IDX_W too narrow");
   end

   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (vec[i]) begin
            any = 1'b1;
            idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/port_table.sv
module port_table #(
   parameter int unsigned ENTRIES = 8,
   parameter int unsigned IDX_W   = 3,
   parameter int unsigned PORT_W  = 3
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [PORT_W-1:0] wr_port,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [PORT_W-1:0] rd_port
);
   logic [PORT_W-1:0] mem [ENTRIES];

   initial begin
      assert (PORT_W > 0) else $error("port_table: PORT_W must be positive");
   end

   for (genvar g = 0; g < ENTRIES; g++) begin : g_word
      always_ff @(posedge clk) begin
         if (wr_en && (wr_idx == IDX_W'(g))) mem[g] <= wr_port;
      end
   end

   assign rd_port = mem[rd_idx];
endmodule

// File: rtl/route_lookup_engine.sv
module route_lookup_engine #(
   parameter int unsigned KEY_W        = 5,
   parameter int unsigned ENTRIES      = 8,
   parameter int unsigned PORT_W       = 3,
   parameter int unsigned DEFAULT_PORT = 7,
   localparam int unsigned IDX_W       = lkup_pkg::idx_width(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [KEY_W-1:0]  wr_value,
   input  logic [KEY_W-1:0]  wr_care,
   input  logic              wr_live,
   input  logic [PORT_W-1:0] wr_port,
   input  logic              lk_req,
   input  logic [KEY_W-1:0]  lk_key,
   output logic              res_valid,
   output logic              res_hit,
   output logic [PORT_W-1:0] res_port
);
   localparam logic [PORT_W-1:0] DEF_P = PORT_W'(DEFAULT_PORT);

   initial begin
      assert (DEFAULT_PORT < (1 << PORT_W))
         else $error("route_lookup_engine: DEFAULT_PORT does not fit PORT_W");
   end

   logic [ENTRIES-1:0] match_vec;
   logic               enc_hit;
   logic [IDX_W-1:0]   enc_idx;
   logic               s1_valid, s1_hit;
   logic [IDX_W-1:0]   s1_idx;
   logic [PORT_W-1:0]  rd_port;

   tcam_bank #(.KEY_W(KEY_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_tcam (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_value(wr_value), .wr_care(wr_care), .wr_live(wr_live),
      .key(lk_key), .match_vec(match_vec));

   first_set_encoder #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_enc (
      .vec(match_vec), .any(enc_hit), .idx(enc_idx));

   // stage 1: registered search result
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_hit   <= 1'b0;
         s1_idx   <= '0;
      end else begin
         s1_valid <= lk_req;
         s1_hit   <= lk_req && enc_hit;
         s1_idx   <= enc_idx;
      end
   end

   port_table #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .PORT_W(PORT_W)) u_ports (
      .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_port(wr_port),
      .rd_idx(s1_idx), .rd_port(rd_port));

   // stage 2: registered port read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_hit   <= 1'b0;
         res_port  <= DEF_P;
      end else begin
         res_valid <= s1_valid;
         res_hit   <= s1_valid && s1_hit;
         res_port  <= (s1_valid && s1_hit) ? rd_port : DEF_P;
      end
   end

   // R2: a result only appears two edges after a request
   p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(lk_req, 2));

   // R6: misses report the default route
   p_miss_default_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_hit) |-> (res_port == DEF_P));

   // R4: the encoder picks a set bit with nothing set below it
   p_lowest_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      enc_hit |-> (match_vec[enc_idx] &&
                   ((match_vec & ((ENTRIES'(1) << enc_idx) - ENTRIES'(1))) == '0)));

   // R1: no hit flag without a valid strobe
   p_hit_needs_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
      res_hit |-> res_valid);
endmodule

// File: tb/tb_route_lookup_engine.sv
module tb_route_lookup_engine;
   localparam int DEF = 7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_idx = '0;
   logic [4:0] wr_value = '0, wr_care = '0;
   logic       wr_live = 1'b0;
   logic [2:0] wr_port = '0;
   logic       lk_req = 1'b0;
   logic [4:0] lk_key = '0;
   logic       res_valid, res_hit;
   logic [2:0] res_port;

   int n_checks = 0;
   int n_fail = 0;
   string tag = "R1";

   route_lookup_engine #(.KEY_W(5), .ENTRIES(8), .PORT_W(3), .DEFAULT_PORT(DEF)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_value(wr_value), .wr_care(wr_care), .wr_live(wr_live),
      .wr_port(wr_port), .lk_req(lk_req), .lk_key(lk_key),
      .res_valid(res_valid), .res_hit(res_hit), .res_port(res_port));

   always #10 clk = ~clk;

   // behavioural model
   bit [4:0] m_val [8];
   bit [4:0] m_care[8];
   bit       m_live[8];
   bit [2:0] m_port[8];
   bit       p1_v, p1_h;
   int       p1_i;
   bit       e_v, e_h;
   bit [2:0] e_p;

   function automatic bit row_hits(input int r, input bit [4:0] k);
      for (int b = 0; b < 5; b++)
         if (m_care[r][b] && (k[b] != m_val[r][b])) return 1'b0;
      return m_live[r];
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int r = 0; r < 8; r++) m_live[r] = 1'b0;
         p1_v = 0; p1_h = 0; p1_i = 0; e_v = 0; e_h = 0; e_p = 3'(DEF);
      end else begin
         e_v = p1_v;
         e_h = p1_v && p1_h;
         e_p = e_h ? m_port[p1_i] : 3'(DEF);
         p1_v = lk_req;
         p1_h = 1'b0;
         p1_i = 0;
         if (lk_req)
            for (int r = 0; r < 8; r++)
               if (!p1_h && row_hits(r, lk_key)) begin p1_h = 1'b1; p1_i = r; end
         if (wr_en) begin
            m_val[wr_idx] = wr_value; m_care[wr_idx] = wr_care;
            m_live[wr_idx] = wr_live; m_port[wr_idx] = wr_port;
         end
      end
   end

   task automatic chk(input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!rst_n) begin
         chk("res_valid in reset", int'(res_valid), 0);
         chk("res_hit in reset", int'(res_hit), 0);
      end else begin
         chk("res_valid", int'(res_valid), int'(e_v));
         if (e_v) begin
            chk("res_hit", int'(res_hit), int'(e_h));
            chk("res_port", int'(res_port), int'(e_p));
         end
      end
   end

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic idle(input int n);
      wr_en = 0; lk_req = 0;
      repeat (n) step();
   endtask

   task automatic put(input int idx, input bit [4:0] v, input bit [4:0] c,
                      input int p, input bit live);
      wr_en = 1; wr_idx = 3'(idx); wr_value = v; wr_care = c;
      wr_port = 3'(p); wr_live = live;
   endtask

   task automatic look(input bit [4:0] k);
      lk_req = 1; lk_key = k;
   endtask

   initial begin
      #200000000;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1 / R6: empty table misses with default port
      tag = "R1";
      look(5'b01101); step(); look(5'b00000); step(); look(5'b11111); step();
      idle(3);
      // R7: load the routing table, A=1 B=2 C=3 D=4
      tag = "R7";
      put(0, 5'b10100, 5'b11100, 1, 1); step();
      put(1, 5'b01100, 5'b11110, 2, 1); step();
      put(2, 5'b01100, 5'b11100, 3, 1); step();
      put(3, 5'b10011, 5'b11111, 4, 1); step();
      idle(1);
      // R3: a prefix row covers its range
      tag = "R3";
      for (int k = 5'b10100; k <= 5'b10111; k++) begin look(5'(k)); step(); end
      look(5'b10011); step();
      idle(3);
      // R6: key outside all rows
      tag = "R6";
      look(5'b10010); step(); look(5'b11000); step();
      idle(3);
      // R4 / R5: overlapping prefixes, lowest row wins
      tag = "R4";
      look(5'b01101); step(); look(5'b01100); step(); look(5'b01110); step();
      idle(3);
      tag = "R5";
      look(5'b01111); step(); look(5'b10110); step();
      idle(3);
      // R2: back-to-back sweep of all keys
      tag = "R2";
      for (int k = 0; k < 32; k++) begin look(5'(k)); step(); end
      idle(4);
      // R8: write at the same edge as a lookup
      tag = "R8";
      look(5'b01101); put(1, 5'b01100, 5'b11110, 5, 1); step();
      wr_en = 0; lk_req = 0; step();
      look(5'b01101); put(1, 5'b00000, 5'b11111, 6, 1); step();
      wr_en = 0; look(5'b01101); step();
      idle(3);
      // R7: removal of a row
      tag = "R7";
      put(2, 5'b01100, 5'b11100, 3, 0); step();
      look(5'b01101); wr_en = 0; step(); look(5'b00000); step();
      idle(3);
      // R2: mixed writes and lookups
      tag = "R2";
      for (int k = 0; k < 40; k++) begin
         lk_req = (k % 3) != 2; lk_key = 5'((k * 7) % 32);
         wr_en = (k % 5) == 0; wr_idx = 3'(k % 8); wr_value = 5'((k * 11) % 32);
         wr_care = 5'b11000 | 5'(k % 8); wr_live = (k % 4) != 3; wr_port = 3'(k % 8);
         step();
      end
      idle(4);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule